// File: doc/BRIEF.md
# Odd-Weight-Column SECDED Codec

This block protects a small data word with a single-error-correcting, double-error-detecting code. The encoder is purely combinational: it takes a data word and returns a systematic codeword. The check bits sit in the low bits of the codeword and the data in the high bits. The decoder takes a received codeword on a valid strobe and, one clock later, presents four things:
- the corrected data;
- a one-hot verdict (clean, fixed or failed);
- the raw syndrome;
- the index of the bit it repaired.

Every column of the parity-check matrix has odd weight. The check columns have weight one and the data columns weight three or more. The error class therefore follows from the weight parity of the syndrome alone, with no extra overall-parity bit:
- An odd syndrome that equals a column is one flipped bit.
- A nonzero even syndrome is two flipped bits.
- An odd syndrome that equals no column is a wider upset, and it is flagged rather than miscorrected.

The default configuration is 4 data bits and 4 check bits, which gives an 8-bit codeword with minimum distance 4. Wider configurations build their matrix from ascending odd-weight values.

Top module: `secded_codec`

## Requirements
- R1: With the default widths, `enc_code_o[7:4]` equals `enc_data_i` and the check bits are `c0=d0^d1^d2`, `c1=d1^d2^d3`, `c2=d0^d2^d3` and `c3=d0^d1^d3` at `enc_code_o[3:0]`. The encoder is combinational.
- R2: Syndrome bit i is the XOR of the received bits selected by a row mask over codeword bits 7..0. The masks are s0: 0111_0001, s1: 1110_0010, s2: 1101_0100 and s3: 1011_1000. A valid codeword gives zero.
- R3: A zero syndrome raises only `dec_clean_o`, returns bits 7..4 of the received word as data, and reports position 0.
- R4: A received word one bit away from a codeword raises only `dec_fixed_o`, returns the original data, and reports the flipped codeword bit index (0 = LSB) on `dec_pos_o`.
- R5: A nonzero even-weight syndrome, which covers every two-bit flip, raises only `dec_fail_o`. The received data field is passed through uncorrected and position 0 is reported.
- R6: An odd-weight syndrome that equals no matrix column raises only `dec_fail_o`. No bit is corrected and position 0 is reported.
- R7: Decoder results are registered. `dec_valid_o` equals `dec_valid_i` of the previous cycle, and each valid result has exactly one flag set.
- R8: While `dec_valid_i` is low, the data, flags, syndrome and position outputs hold their values whatever `dec_code_i` carries.
- R9: An active-low asynchronous reset clears `dec_valid_o`, all flags, data, syndrome and position, and a valid strobe during reset has no effect.
- R10: For widths other than 4+4, check column j is `1<<j` and data column k is the k-th value, in ascending order, with odd weight of at least 3. For DATA_W=8 and CHK_W=5 these are 7, 11, 13, 14, 19, 21, 22 and 25. R1 to R6 then hold with this matrix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_data_i | input | DATA_W | Data word to encode |
| enc_code_o | output | DATA_W+CHK_W | Codeword: data high, check bits low |
| dec_valid_i | input | 1 | Received word valid this cycle |
| dec_code_i | input | DATA_W+CHK_W | Received codeword |
| dec_valid_o | output | 1 | Result valid, one cycle after input |
| dec_data_o | output | DATA_W | Corrected (or passed-through) data |
| dec_clean_o | output | 1 | Zero syndrome |
| dec_fixed_o | output | 1 | One bit corrected |
| dec_fail_o | output | 1 | Uncorrectable word |
| dec_syn_o | output | CHK_W | Syndrome of the received word |
| dec_pos_o | output | $clog2(DATA_W+CHK_W) | Corrected bit index, 0 unless fixed |

## Verification
Encoding and decoding share a cycle. The bench encodes a fresh data word on every cycle of the decoder sweep. It also streams received words back to back, so a registered verdict leaves in the same cycle that the next word is captured. Each cycle's encoder output is judged against a codebook built in the bench from the R1 and R10 equations. The decoder result is judged against a brute-force nearest-codeword search over that codebook. This search covers every 8-bit received word in the default configuration and every 13-bit word in the wide one, so every two-bit and wider pattern is reached, including odd syndromes outside the matrix.

// File: rtl/secded_pkg.sv
package secded_pkg;

   typedef enum logic [1:0] {
      CLS_CLEAN = 2'd0,
      CLS_FIXED = 2'd1,
      CLS_FAIL  = 2'd2
   } dec_cls_e;

   // number of set bits among the low n bits of v
   function automatic int ones(input int v, input int n);
      int c;
      c = 0;
      for (int b = 0; b < n; b++) c += (v >> b) & 1;
      return c;
   endfunction

   // how many odd-weight values of weight >= 3 fit in n bits
   function automatic int odd_col_cap(input int n);
      int c;
      c = 0;
      for (int v = 1; v < (1 << n); v++)
         if ((ones(v, n) % 2 == 1) && (ones(v, n) >= 3)) c++;
      return c;
   endfunction

   // k-th odd-weight value of weight >= 3, ascending
   function automatic int odd_col(input int k, input int n);
      int c;
      int r;
      c = 0;
      r = 0;
      for (int v = 1; v < (1 << n); v++) begin
         if ((ones(v, n) % 2 == 1) && (ones(v, n) >= 3)) begin
            if (c == k) r = v;
            c++;
         end
      end
      return r;
   endfunction

   // data columns of the 4+4 base matrix, syndrome bit 0 in the LSB
   function automatic int base_col(input int k);
      case (k)
         0:       return 13;
         1:       return 11;
         2:       return 7;
         default: return 14;
      endcase
   endfunction

endpackage

// File: rtl/secded_hmat.sv
module secded_hmat #(
   parameter int DATA_W = 4,
   parameter int CHK_W  = 4
) (
   output logic [DATA_W+CHK_W-1:0][CHK_W-1:0] cols_o
);
   localparam int CW_W = DATA_W + CHK_W;

   // identity part: check bits
   for (genvar j = 0; j < CHK_W; j++) begin : g_id
      assign cols_o[j] = CHK_W'(1) << j;
   end

   if (DATA_W == 4 && CHK_W == 4) begin : g_base
      for (genvar k = 0; k < DATA_W; k++) begin : g_col
         assign cols_o[CHK_W+k] = CHK_W'(secded_pkg::base_col(k));
      end
   end else begin : g_gen
      for (genvar k = 0; k < DATA_W; k++) begin : g_col
         assign cols_o[CHK_W+k] = CHK_W'(secded_pkg::odd_col(k, CHK_W));
      end
   end

   if (CW_W < 4) begin : g_small
      $error("secded_hmat: codeword too short");
   end
endmodule

// File: rtl/secded_enc.sv
module secded_enc #(
   parameter int DATA_W = 4,
   parameter int CHK_W  = 4
) (
   input  logic [DATA_W-1:0][CHK_W-1:0] dcols_i,
   input  logic [DATA_W-1:0]            data_i,
   output logic [DATA_W+CHK_W-1:0]      code_o
);
   logic [CHK_W-1:0] chk;

   always_comb begin
      chk = '0;
      for (int k = 0; k < DATA_W; k++)
         if (data_i[k]) chk = chk ^ dcols_i[k];
   end

   assign code_o = {data_i, chk};
endmodule

// File: rtl/secded_syn.sv
module secded_syn #(
   parameter int DATA_W = 4,
   parameter int CHK_W  = 4
) (
   input  logic [DATA_W+CHK_W-1:0][CHK_W-1:0] cols_i,
   input  logic [DATA_W+CHK_W-1:0]            code_i,
   output logic [CHK_W-1:0]                   syn_o
);
   localparam int CW_W = DATA_W + CHK_W;

   // accumulating columns of set bits equals masking each row
   always_comb begin
      syn_o = '0;
      for (int j = 0; j < CW_W; j++)
         if (code_i[j]) syn_o = syn_o ^ cols_i[j];
   end
endmodule

// File: rtl/secded_loc.sv
module secded_loc #(
   parameter int DATA_W = 4,
   parameter int CHK_W  = 4,
   parameter int IDX_W  = 3
) (
   input  logic [DATA_W+CHK_W-1:0][CHK_W-1:0] cols_i,
   input  logic [DATA_W+CHK_W-1:0]            code_i,
   input  logic [CHK_W-1:0]                   syn_i,
   output secded_pkg::dec_cls_e               cls_o,
   output logic [DATA_W-1:0]                  data_o,
   output logic [IDX_W-1:0]                   pos_o
);
   localparam int CW_W = DATA_W + CHK_W;

   logic [CW_W-1:0] hit;
   logic [CW_W-1:0] flip;
   logic            odd_w;
   logic            zero_w;
   logic            fix_w;

   for (genvar j = 0; j < CW_W; j++) begin : g_cmp
      assign hit[j] = (syn_i == cols_i[j]);
   end

   assign odd_w  = ^syn_i;
   assign zero_w = ~|syn_i;
   assign fix_w  = odd_w & (|hit);
   assign flip   = fix_w ? hit : '0;

   always_comb begin
      pos_o = '0;
      for (int j = 0; j < CW_W; j++)
         if (flip[j]) pos_o = IDX_W'(j);
   end

   assign data_o = code_i[CW_W-1:CHK_W] ^ flip[CW_W-1:CHK_W];

   always_comb begin
      if (zero_w)     cls_o = secded_pkg::CLS_CLEAN;
      else if (fix_w) cls_o = secded_pkg::CLS_FIXED;
      else            cls_o = secded_pkg::CLS_FAIL;
   end
endmodule

// File: rtl/secded_codec.sv
module secded_codec #(
   parameter int DATA_W = 4,
   parameter int CHK_W  = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [DATA_W-1:0]                enc_data_i,
   output logic [DATA_W+CHK_W-1:0]          enc_code_o,
   input  logic                             dec_valid_i,
   input  logic [DATA_W+CHK_W-1:0]          dec_code_i,
   output logic                             dec_valid_o,
   output logic [DATA_W-1:0]                dec_data_o,
   output logic                             dec_clean_o,
   output logic                             dec_fixed_o,
   output logic                             dec_fail_o,
   output logic [CHK_W-1:0]                 dec_syn_o,
   output logic [$clog2(DATA_W+CHK_W)-1:0]  dec_pos_o
);
   localparam int CW_W  = DATA_W + CHK_W;
   localparam int IDX_W = $clog2(CW_W);
   localparam int CAP   = secded_pkg::odd_col_cap(CHK_W);

   if (CHK_W < 3) begin : g_chk_small
      $error("secded_codec: CHK_W must be at least 3");
   end
   if (DATA_W < 1 || DATA_W > CAP) begin : g_data_range
      $error("secded_codec: DATA_W exceeds odd-weight columns available");
   end

   logic [CW_W-1:0][CHK_W-1:0] cols;
   logic [CHK_W-1:0]           syn_w;
   secded_pkg::dec_cls_e       cls_w;
   logic [DATA_W-1:0]          data_w;
   logic [IDX_W-1:0]           pos_w;

   secded_hmat #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_hmat (
      .cols_o (cols)
   );

   secded_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
      .dcols_i (cols[CW_W-1:CHK_W]),
      .data_i  (enc_data_i),
      .code_o  (enc_code_o)
   );

   secded_syn #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_syn (
      .cols_i (cols),
      .code_i (dec_code_i),
      .syn_o  (syn_w)
   );

   secded_loc #(.DATA_W(DATA_W), .CHK_W(CHK_W), .IDX_W(IDX_W)) u_loc (
      .cols_i (cols),
      .code_i (dec_code_i),
      .syn_i  (syn_w),
      .cls_o  (cls_w),
      .data_o (data_w),
      .pos_o  (pos_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid_o <= 1'b0;
         dec_data_o  <= '0;
         dec_clean_o <= 1'b0;
         dec_fixed_o <= 1'b0;
         dec_fail_o  <= 1'b0;
         dec_syn_o   <= '0;
         dec_pos_o   <= '0;
      end else begin
         dec_valid_o <= dec_valid_i;
         if (dec_valid_i) begin
            dec_data_o  <= data_w;
            dec_clean_o <= (cls_w == secded_pkg::CLS_CLEAN);
            dec_fixed_o <= (cls_w == secded_pkg::CLS_FIXED);
            dec_fail_o  <= (cls_w == secded_pkg::CLS_FAIL);
            dec_syn_o   <= syn_w;
            dec_pos_o   <= pos_w;
         end
      end
   end
endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk #(
   parameter int DATA_W = 4,
   parameter int CHK_W  = 4
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic [DATA_W-1:0]                enc_data_i,
   input logic [DATA_W+CHK_W-1:0]          enc_code_o,
   input logic                             dec_valid_i,
   input logic                             dec_valid_o,
   input logic [DATA_W-1:0]                dec_data_o,
   input logic                             dec_clean_o,
   input logic                             dec_fixed_o,
   input logic                             dec_fail_o,
   input logic [CHK_W-1:0]                 dec_syn_o,
   input logic [$clog2(DATA_W+CHK_W)-1:0]  dec_pos_o
);
   localparam int CW_W = DATA_W + CHK_W;

   assert_enc_systematic_R1: assert property (@(posedge clk) disable iff (!rst_n)
      enc_code_o[CW_W-1:CHK_W] == enc_data_i);

   assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid_i |=> dec_valid_o);

   assert_valid_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid_i |=> !dec_valid_o);

   assert_one_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid_o |-> $countones({dec_clean_o, dec_fixed_o, dec_fail_o}) == 1);

   assert_clean_zero_syn_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid_o && dec_clean_o) |-> (dec_syn_o == '0 && dec_pos_o == '0));

   assert_fixed_odd_syn_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid_o && dec_fixed_o) |-> ((^dec_syn_o) && (int'(dec_pos_o) < CW_W)));

   assert_fail_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid_o && dec_fail_o) |-> (dec_syn_o != '0 && dec_pos_o == '0));

   assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid_i |=> ($stable(dec_data_o) && $stable(dec_syn_o) && $stable(dec_pos_o)
                        && $stable({dec_clean_o, dec_fixed_o, dec_fail_o})));
endmodule

bind secded_codec secded_codec_chk #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .enc_data_i  (enc_data_i),
   .enc_code_o  (enc_code_o),
   .dec_valid_i (dec_valid_i),
   .dec_valid_o (dec_valid_o),
   .dec_data_o  (dec_data_o),
   .dec_clean_o (dec_clean_o),
   .dec_fixed_o (dec_fixed_o),
   .dec_fail_o  (dec_fail_o),
   .dec_syn_o   (dec_syn_o),
   .dec_pos_o   (dec_pos_o)
);

// File: tb/secded_codec_tb_top.sv
`timescale 1ns/1ps
module secded_codec_tb_top;
   localparam int AD = 4, AC = 4, AN = 8, AI = 3;
   localparam int BD = 8, BC = 5, BN = 13, BI = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [AD-1:0] a_enc;  logic [AN-1:0] a_code_o;
   logic a_val;           logic [AN-1:0] a_code;
   logic a_vo;            logic [AD-1:0] a_data;
   logic a_cl, a_fx, a_fl; logic [AC-1:0] a_syn; logic [AI-1:0] a_pos;

   logic [BD-1:0] b_enc;  logic [BN-1:0] b_code_o;
   logic b_val;           logic [BN-1:0] b_code;
   logic b_vo;            logic [BD-1:0] b_data;
   logic b_cl, b_fx, b_fl; logic [BC-1:0] b_syn; logic [BI-1:0] b_pos;

   secded_codec dut_i (
      .clk(clk), .rst_n(rst_n), .enc_data_i(a_enc), .enc_code_o(a_code_o),
      .dec_valid_i(a_val), .dec_code_i(a_code), .dec_valid_o(a_vo),
      .dec_data_o(a_data), .dec_clean_o(a_cl), .dec_fixed_o(a_fx),
      .dec_fail_o(a_fl), .dec_syn_o(a_syn), .dec_pos_o(a_pos));

   secded_codec #(.DATA_W(BD), .CHK_W(BC)) dut_w_i (
      .clk(clk), .rst_n(rst_n), .enc_data_i(b_enc), .enc_code_o(b_code_o),
      .dec_valid_i(b_val), .dec_code_i(b_code), .dec_valid_o(b_vo),
      .dec_data_o(b_data), .dec_clean_o(b_cl), .dec_fixed_o(b_fx),
      .dec_fail_o(b_fl), .dec_syn_o(b_syn), .dec_pos_o(b_pos));

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   int cols_a [AN];
   int cols_b [BN];
   int cb_a   [16];
   int cb_b   [256];

   function automatic int popc(input int v);
      int c;
      c = 0;
      for (int b = 0; b < 32; b++) c += (v >> b) & 1;
      return c;
   endfunction

   // R2 row masks and R10 column rule, tables built from the requirements
   task automatic build_tables();
      int masks [4];
      int k;
      masks = '{8'h71, 8'he2, 8'hd4, 8'hb8};
      for (int j = 0; j < AN; j++) begin
         cols_a[j] = 0;
         for (int i = 0; i < AC; i++) cols_a[j] |= ((masks[i] >> j) & 1) << i;
      end
      for (int j = 0; j < BC; j++) cols_b[j] = 1 << j;
      k = 0;
      for (int v = 1; v < 32; v++)
         if ((popc(v) % 2 == 1) && popc(v) >= 3 && k < BD) begin
            cols_b[BC+k] = v;
            k++;
         end
      for (int d = 0; d < 16; d++) begin
         int s;
         s = 0;
         for (int k2 = 0; k2 < AD; k2++) if ((d >> k2) & 1) s ^= cols_a[AC+k2];
         cb_a[d] = (d << AC) | s;
      end
      for (int d = 0; d < 256; d++) begin
         int s;
         s = 0;
         for (int k2 = 0; k2 < BD; k2++) if ((d >> k2) & 1) s ^= cols_b[BC+k2];
         cb_b[d] = (d << BC) | s;
      end
   endtask

   // nearest-codeword decision: cls 0 clean, 1 fixed, 2 fail
   task automatic expect_dec(input bit w, input int r, output int ed, output int ecls,
                             output int epos, output int esyn);
      int nd, cw, n;
      nd = w ? 256 : 16;
      cw = w ? BC : AC;
      n  = w ? BN : AN;
      ecls = 2; ed = r >> cw; epos = 0; esyn = 0;
      for (int j = 0; j < n; j++)
         if ((r >> j) & 1) esyn ^= (w ? cols_b[j] : cols_a[j]);
      for (int d = 0; d < nd; d++) begin
         int c, x;
         c = w ? cb_b[d] : cb_a[d];
         x = c ^ r;
         if (x == 0) begin ecls = 0; ed = d; epos = 0; end
         else if (popc(x) == 1 && ecls != 0) begin
            ecls = 1; ed = d;
            for (int j = 0; j < n; j++) if ((x >> j) & 1) epos = j;
         end
      end
   endtask

   function automatic string tag_of(input int ecls, input int esyn);
      if (ecls == 0) return "R3";
      if (ecls == 1) return "R4";
      if (popc(esyn) % 2 == 0) return "R5";
      return "R6";
   endfunction

   task automatic judge(input bit w, input int r, input int vo, input int d, input int cl,
                        input int fx, input int fl, input int sy, input int ps);
      int ed, ecls, epos, esyn;
      int gflags, eflags;
      string t;
      expect_dec(w, r, ed, ecls, epos, esyn);
      t = tag_of(ecls, esyn);
      gflags = (cl << 2) | (fx << 1) | fl;
      eflags = (ecls == 0) ? 4 : (ecls == 1) ? 2 : 1;
      checks++;
      if (vo != 1 || d != ed || gflags != eflags || ps != epos) begin
         fails++;
         $display("FAIL %s%s R7 word=%h got v=%0d d=%h f=%b p=%0d exp v=1 d=%h f=%b p=%0d",
                  t, w ? " R10" : "", r, vo, d, gflags[2:0], ps, ed, eflags[2:0], epos);
      end
      checks++;
      if (sy != esyn) begin
         fails++;
         $display("FAIL %s word=%h syndrome got %h exp %h", w ? "R10" : "R2", r, sy, esyn);
      end
   endtask

   task automatic run_a(input int r);
      a_code = AN'(r); a_val = 1'b1; a_enc = AD'(r & 15);
      #1;
      checks++;
      if (int'(a_code_o) != cb_a[r & 15]) begin
         fails++;
         $display("FAIL R1 data=%h got %h exp %h", r & 15, a_code_o, cb_a[r & 15]);
      end
      @(negedge clk);
      judge(1'b0, r, int'(a_vo), int'(a_data), int'(a_cl), int'(a_fx), int'(a_fl),
            int'(a_syn), int'(a_pos));
   endtask

   task automatic run_b(input int r);
      b_code = BN'(r); b_val = 1'b1; b_enc = BD'(r & 255);
      #1;
      checks++;
      if (int'(b_code_o) != cb_b[r & 255]) begin
         fails++;
         $display("FAIL R1 R10 data=%h got %h exp %h", r & 255, b_code_o, cb_b[r & 255]);
      end
      @(negedge clk);
      judge(1'b1, r, int'(b_vo), int'(b_data), int'(b_cl), int'(b_fx), int'(b_fl),
            int'(b_syn), int'(b_pos));
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired got running exp finished");
         summary();
         $finish;
      end
   end

   initial begin
      int g;
      build_tables();
      a_enc = '0; a_code = 8'h3c; a_val = 1'b1;
      b_enc = '0; b_code = 13'h0a5; b_val = 1'b1;
      repeat (3) @(negedge clk);
      // R9: strobes during reset must leave everything cleared
      g = int'({a_vo, a_cl, a_fx, a_fl}) + int'(a_data) + int'(a_syn) + int'(a_pos);
      checks++;
      if (g != 0) begin fails++; $display("FAIL R9 default outputs got %0d exp 0", g); end
      g = int'({b_vo, b_cl, b_fx, b_fl}) + int'(b_data) + int'(b_syn) + int'(b_pos);
      checks++;
      if (g != 0) begin fails++; $display("FAIL R9 wide outputs got %0d exp 0", g); end
      a_val = 1'b0; b_val = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (a_vo !== 1'b0) begin fails++; $display("FAIL R7 idle valid got %b exp 0", a_vo); end

      // exhaustive default sweep: clean, all single and double flips, wider
      for (int r = 0; r < 256; r++) run_a(r);

      // R8: drop the strobe with a different word present; last result is 0xFF (clean, data F)
      a_val = 1'b0; a_code = 8'h5a;
      @(negedge clk);
      checks++;
      if (a_vo !== 1'b0 || a_data !== 4'hf || {a_cl, a_fx, a_fl} !== 3'b100
          || a_syn !== 4'h0 || a_pos !== 3'd0) begin
         fails++;
         $display("FAIL R8 hold got v=%b d=%h f=%b s=%h p=%0d exp v=0 d=f f=100 s=0 p=0",
                  a_vo, a_data, {a_cl, a_fx, a_fl}, a_syn, a_pos);
      end
      @(negedge clk);
      checks++;
      if (a_data !== 4'hf || a_syn !== 4'h0) begin
         fails++;
         $display("FAIL R8 second idle cycle got d=%h s=%h exp d=f s=0", a_data, a_syn);
      end
      run_a(8'h5a);
      a_val = 1'b0;

      // R10 wide configuration, every 13-bit received word
      for (int r = 0; r < 8192; r++) run_b(r);
      b_val = 1'b0;
      @(negedge clk);
      checks++;
      if (b_vo !== 1'b0) begin fails++; $display("FAIL R7 wide valid got %b exp 0", b_vo); end

      done = 1;
      summary();
      $finish;
   end
endmodule